// File: doc/BRIEF.md
# Programmable-Priority Interrupt Arbiter

This block sits between thirteen peripheral interrupt lines and a processor's interrupt input. Each line is sampled into a pending register. A mask register blocks chosen sources. One 8-bit control register per source carries a 5-bit ranking field. Every cycle the arbiter picks the unmasked pending source with the highest ranking. It then drives the processor interrupt level taken from that field, together with a vector for the winner.

Two sources are serial ports, and each of them supplies its own vector through a software-written vector register. Every other source produces an automatic vector that depends on its level. Software reads and writes all registers over a single-cycle register bus. Reads are combinational. A write takes effect at the clock edge on which it is presented.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset: every control register reads 0; the mask register (address 16, bits 13:1) reads 0x3FFE; the pending register reads 0; both serial vector registers read 0x0F; the outputs are level 0, vector 0 and winner 0.
- R2: Pending bit k (address 17, bit k) equals input line k as sampled at the previous clock edge. It is set while the line is high and clears once the line is low. Writes to address 17 have no effect.
- R3: A source is active only if its pending bit is 1 and its mask bit is 0. A mask bit written to 1 keeps its source out of arbitration.
- R4: The winner is the active source whose control bits [4:0] hold the strictly largest value. On a tie the lower-numbered source wins. A source whose bits [4:0] are zero never wins. The winner output is 0 when no source wins.
- R5: The level output equals bits [4:2] of the winner's control register, and it is 0 when there is no winner.
- R6: When source 12 wins, the vector output is the register at address 18. When source 13 wins, it is the register at address 19. Any other winner gives 24 plus the level. With no winner the vector is 0.
- R7: Control register k sits at address k (1 to 13) and reads back all 8 written bits. Bits 7:5 have no effect on arbitration.
- R8: Outputs reflect a control, mask or line change in the cycle right after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 13 | Interrupt lines; bit k-1 is source k |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cpu_level | output | 3 | Processor interrupt level |
| cpu_vector | output | 8 | Vector for the winning source |
| win_id | output | 4 | Winning source number, 0 if none |

## Verification
The bench sweeps every ranking value on every source on its own. This catches a zero-ranked source that is wrongly allowed to win, a level taken from the wrong bits, and an automatic vector given to a serial port. It also sets up ties between source pairs: a design using greater-or-equal would hand the win to the higher-numbered source. A long pseudo-random run varies lines, masks and control bytes, including bits 7:5, and compares against an arithmetic model. That run exposes inverted mask polarity, pending bits that fail to clear, and upper control bits leaking into the comparison.

// File: rtl/irq_arb_pkg.sv
// Shared constants and register addresses for the interrupt arbiter.
// Assumes at most 15 sources so a 4-bit winner number is enough.
package irq_arb_pkg;
    localparam int PRIO_W     = 5;
    localparam int ADDR_MASK  = 16;
    localparam int ADDR_PEND  = 17;
    localparam int ADDR_VEC_A = 18;
    localparam int ADDR_VEC_B = 19;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_pend_mask.sv
// Pending and mask state. Pending mirrors the input lines one edge late;
// mask is software-written and resets to all ones (everything blocked).
// Assumes mask_we is already qualified with the mask address.
module irq_pend_mask #(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   lines,
    input  logic               mask_we,
    input  logic [NUM_SRC:1]   mask_wdata,
    output logic [NUM_SRC:1]   pend_q,
    output logic [NUM_SRC:1]   mask_q
);
    // Sample the interrupt lines into the pending register
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= lines;
    end

    // Hold the software mask
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // R2
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(lines));
    // R1
    mask_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> &mask_q);
endmodule

// File: rtl/irq_ctrl_bank.sv
// Per-source control bytes and the two serial-port vector registers.
// Assumes control register k is at address k, vector registers at the
// package addresses.
module irq_ctrl_bank #(
    parameter int         NUM_SRC   = 13,
    parameter int         ADDR_W    = 5,
    parameter logic [7:0] VEC_RESET = 8'h0F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [NUM_SRC:1][7:0]  ctrl_q,
    output logic [7:0]             vec_a_q,
    output logic [7:0]             vec_b_q
);
    import irq_arb_pkg::*;

    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_ctrl
        // Control byte for source k
        always_ff @(posedge clk) begin
            if (!rst_n)                              ctrl_q[k] <= '0;
            else if (we && addr == ADDR_W'(k))       ctrl_q[k] <= wdata;
        end
    end

    // Serial-port vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_a_q <= VEC_RESET;
            vec_b_q <= VEC_RESET;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_VEC_A)) vec_a_q <= wdata;
            if (addr == ADDR_W'(ADDR_VEC_B)) vec_b_q <= wdata;
        end
    end
endmodule

// File: rtl/irq_pick.sv
// Combinational arbiter: scans sources upward and keeps the first one with a
// strictly larger ranking, so lower numbers win ties and rank 0 never wins.
module irq_pick #(
    parameter int NUM_SRC = 13,
    parameter int ID_W    = 4
) (
    input  logic [NUM_SRC:1]        active,
    input  logic [NUM_SRC:1][7:0]   ctrl,
    output logic [ID_W-1:0]         win,
    output irq_arb_pkg::prio_t      win_prio
);
    import irq_arb_pkg::*;

    // Linear scan for the strictly largest ranking
    always_comb begin
        win      = '0;
        win_prio = '0;
        for (int k = 1; k <= NUM_SRC; k++) begin
            if (active[k] && ctrl[k][PRIO_W-1:0] > win_prio) begin
                win_prio = ctrl[k][PRIO_W-1:0];
                win      = ID_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
// Top of the programmable-priority interrupt arbiter: register bus decode,
// read mux, level and vector generation. Assumes single-cycle bus writes and
// a combinational read path.
module irq_prio_arb #(
    parameter int         NUM_SRC      = 13,
    parameter int         SER_A        = 12,
    parameter int         SER_B        = 13,
    parameter int         AUTOVEC_BASE = 24,
    parameter logic [7:0] VEC_RESET    = 8'h0F,
    parameter int         ADDR_W       = 5,
    parameter int         DATA_W       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [2:0]           cpu_level,
    output logic [7:0]           cpu_vector,
    output logic [3:0]           win_id
);
    import irq_arb_pkg::*;
    localparam int ID_W = 4;

    logic [NUM_SRC:1]       pend_q, mask_q, active;
    logic [NUM_SRC:1][7:0]  ctrl_q;
    logic [7:0]             vec_a_q, vec_b_q;
    prio_t                  win_prio;
    logic                   mask_we;

    assign mask_we = bus_wr && bus_addr == ADDR_W'(ADDR_MASK);

    irq_pend_mask #(.NUM_SRC(NUM_SRC)) u_pm (
        .clk(clk), .rst_n(rst_n), .lines(irq_in),
        .mask_we(mask_we), .mask_wdata(bus_wdata[NUM_SRC:1]),
        .pend_q(pend_q), .mask_q(mask_q));

    irq_ctrl_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_RESET(VEC_RESET)) u_cb (
        .clk(clk), .rst_n(rst_n), .we(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[7:0]), .ctrl_q(ctrl_q),
        .vec_a_q(vec_a_q), .vec_b_q(vec_b_q));

    assign active = pend_q & ~mask_q;

    irq_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
        .active(active), .ctrl(ctrl_q), .win(win_id), .win_prio(win_prio));

    // Level comes from the upper three bits of the winning ranking
    assign cpu_level = win_prio[4:2];

    // Vector select: serial ports supply their own, others autovector
    always_comb begin
        if (win_id == '0)                    cpu_vector = '0;
        else if (win_id == ID_W'(SER_A))     cpu_vector = vec_a_q;
        else if (win_id == ID_W'(SER_B))     cpu_vector = vec_b_q;
        else                                 cpu_vector = 8'(AUTOVEC_BASE) + 8'(cpu_level);
    end

    // Register read mux
    always_comb begin
        bus_rdata = '0;
        for (int k = 1; k <= NUM_SRC; k++)
            if (bus_addr == ADDR_W'(k)) bus_rdata = DATA_W'(ctrl_q[k]);
        if (bus_addr == ADDR_W'(ADDR_MASK))  bus_rdata = DATA_W'({mask_q, 1'b0});
        if (bus_addr == ADDR_W'(ADDR_PEND))  bus_rdata = DATA_W'({pend_q, 1'b0});
        if (bus_addr == ADDR_W'(ADDR_VEC_A)) bus_rdata = DATA_W'(vec_a_q);
        if (bus_addr == ADDR_W'(ADDR_VEC_B)) bus_rdata = DATA_W'(vec_b_q);
    end

    // R5
    level_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_level != 3'd0 |-> win_id != '0);
    // R6
    idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_id == '0 |-> cpu_vector == 8'd0);
    // R6
    ser_a_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_id == ID_W'(SER_A) |-> cpu_vector == vec_a_q);
    // R3
    win_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_id != '0 |-> $countones(active) != 0);

    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_chk
        // R4
        no_better_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            active[k] |-> ctrl_q[k][PRIO_W-1:0] <= win_prio);
    end
endmodule

// File: tb/sim_irq_prio_arb.sv
// Self-checking bench: single-source sweeps, tie pairs and a pseudo-random
// run compared against an arithmetic model.
module sim_irq_prio_arb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [12:0] irq_in = '0;
    logic        bus_wr = 0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;
    logic [3:0]  win_id;

    int checks = 0, errors = 0;
    logic [7:0]  m_ctrl [1:13];
    logic [13:1] m_mask;
    logic [7:0]  m_va, m_vb;
    logic [31:0] seed = 32'h1234_5678;
    bit          done = 0;

    irq_prio_arb u0 (.*);

    always #5 clk = ~clk;

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 5'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        bus_addr = 5'(a);
        #1;
        chk(req, int'(bus_rdata), exp);
    endtask

    function automatic int exp_win();
        int w = 0, best = 0;
        for (int k = 1; k <= 13; k++)
            if (irq_in[k-1] && !m_mask[k] && int'(m_ctrl[k][4:0]) > best) begin
                best = int'(m_ctrl[k][4:0]); w = k;
            end
        return w;
    endfunction

    task automatic chk_out(string req);
        int w = exp_win();
        int lv = (w == 0) ? 0 : int'(m_ctrl[w][4:2]);
        int vc = (w == 0) ? 0 : (w == 12) ? int'(m_va) : (w == 13) ? int'(m_vb) : 24 + lv;
        chk({req, " winner"}, int'(win_id), w);
        chk({req, " level"}, int'(cpu_level), lv);
        chk({req, " vector"}, int'(cpu_vector), vc);
    endtask

    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 1; k <= 13; k++) m_ctrl[k] = '0;
        m_mask = '1; m_va = 8'h0F; m_vb = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int k = 1; k <= 13; k++) rd_chk("R1 ctrl", k, 0);
        rd_chk("R1 mask", 16, 16'h3FFE);
        rd_chk("R1 pend", 17, 0);
        rd_chk("R1 vecA", 18, 8'h0F);
        rd_chk("R1 vecB", 19, 8'h0F);
        chk_out("R1");

        // R3: lines high but all masked, ranking nonzero
        irq_in = '1;
        for (int k = 1; k <= 13; k++) begin wr(k, k + 2); m_ctrl[k] = 8'(k + 2); end
        chk_out("R3 all masked");
        // R2 pending follows lines, write ignored
        wr(17, 0);
        rd_chk("R2 pend high", 17, 16'h3FFE);
        irq_in = 13'h0005;
        @(negedge clk);
        rd_chk("R2 pend drop", 17, 16'h000A);
        irq_in = '0;
        wr(16, 0); m_mask = '0;
        rd_chk("R3 mask wr", 16, 0);

        // R7 readback of all 8 bits
        wr(18, 8'hA5); m_va = 8'hA5;
        wr(19, 8'h5A); m_vb = 8'h5A;
        wr(3, 8'hE7); m_ctrl[3] = 8'hE7;
        rd_chk("R7 ctrl readback", 3, 8'hE7);

        // R4 R5 R6 R8: single source, every ranking (upper bits set too)
        for (int k = 1; k <= 13; k++) begin
            irq_in = 13'(1 << (k - 1));
            for (int p = 0; p < 32; p++) begin
                wr(k, 8'(p | ((p & 7) << 5))); m_ctrl[k] = 8'(p | ((p & 7) << 5));
                chk_out("R4 R5 R6 R8 single");
            end
        end

        // R4 ties: lower number wins
        for (int a = 1; a <= 13; a++)
            for (int b = a + 1; b <= 13; b++) begin
                wr(a, 8'h11); m_ctrl[a] = 8'h11;
                wr(b, 8'hF1); m_ctrl[b] = 8'hF1;
                irq_in = 13'((1 << (a - 1)) | (1 << (b - 1)));
                @(negedge clk);
                chk("R4 tie", int'(win_id), a);
            end

        // R2 R3 R4 R7 R8 pseudo-random run
        for (int n = 0; n < 1500; n++) begin
            seed = nxt(seed);
            case (seed[1:0])
                2'd0: begin
                    int k = 1 + int'(seed[7:4]) % 13;
                    wr(k, int'(seed[15:8])); m_ctrl[k] = seed[15:8];
                end
                2'd1: begin
                    wr(16, int'({seed[28:16], 1'b0})); m_mask = seed[28:16];
                end
                default: begin
                    irq_in = seed[20:8];
                    @(negedge clk);
                end
            endcase
            chk_out("R3 R4 R7 R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule